// File: doc/BRIEF.md
# Doorbell Mailbox Command Interface

This block is the meeting point between a host processor and a power-management microcontroller. The host sees four 32-bit words on a simple register bus. Two of them hold data words, one is the command word and one clears the interrupt. The host loads any input data first. It then writes the command word with its top bit set, which marks the mailbox busy. The controller receives a one-cycle command strobe together with the command code, the two 8-bit parameters and the data words. It answers with a completion strobe that carries an 8-bit error code and, optionally, result words.

On completion the busy bit drops and the error code appears in the low byte of the command word, both in the same cycle. A level interrupt is raised at that moment. A host without an interrupt line polls the busy bit instead; the timeout on that wait belongs to host software. The parameter `HAS_HIGH` decides whether an instance has the second data word.

The controller side has no back-pressure. The controller must take the command strobe in the cycle it is high, since the block never repeats it. The controller may hold back its completion strobe for as long as it needs. While busy the block keeps the command and data outputs frozen, so the controller may sample them at any later point.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset every register reads 0, the interrupt is low and the command strobe is low.
- R2: Word index 0 is the low data word and index 1 the high data word; while idle, a write to either is read back unchanged.
- R3: A write to word index 2 with bit 31 set, while idle, starts a command. It latches the code from bits 30:24, parameter one from bits 15:8 and parameter two from bits 23:16. It sets the busy flag (bit 31) and clears the error byte (bits 7:0), whatever those bits carried in the write.
- R4: `cmd_valid` is high for exactly one cycle: the cycle after the starting write's clock edge. In that cycle the code, parameters and data words are presented on the command outputs.
- R5: While busy, bus writes to word indices 0, 1 and 2 are ignored.
- R6: A completion strobe while busy clears bit 31, loads `done_err` into bits 7:0 and raises the interrupt, all at the same clock edge.
- R7: On a completion whose error code is 0, the result words replace the data words. On a non-zero code the data words keep the values the host wrote.
- R8: The interrupt stays high until a write of 1 to bit 0 of word index 3. Writing 0 there has no effect, and a completion in the same cycle as a clear leaves the interrupt high.
- R9: With `HAS_HIGH` = 0 the high data word always reads 0, and writes and results for it are dropped.
- R10: A completion strobe while idle changes no register and raises no interrupt.
- R11: A write to word index 2 with bit 31 clear, while idle, stores the code and parameter fields without starting a command. It leaves the error byte as it was and produces no command strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Word index: 0 data low, 1 data high, 2 command, 3 interrupt clear |
| bus_wr | input | 1 | Write enable for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Completion interrupt, level |
| cmd_valid | output | 1 | One-cycle command strobe to the controller |
| cmd_code | output | 7 | Command code |
| cmd_p1 | output | 8 | First parameter |
| cmd_p2 | output | 8 | Second parameter |
| cmd_data_lo | output | 32 | Low data word |
| cmd_data_hi | output | 32 | High data word (0 when absent) |
| done | input | 1 | Completion strobe from the controller |
| done_err | input | 8 | Error code, 0 for success |
| done_data_lo | input | 32 | Low result word |
| done_data_hi | input | 32 | High result word |

## Verification
Every register effect is visible on `bus_rdata` right after the clock edge that takes a write or a completion. The bench therefore drives on a falling edge and reads back at the next falling edge. The command strobe is due in the single cycle after the starting write's edge, so it is sampled at exactly that falling edge and again one cycle later to confirm it has gone. The completion flags, error byte, result words and interrupt are all checked at the first falling edge after the completion strobe, to show they change together.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 2;

  localparam logic [IDX_W-1:0] IDX_DLO = 2'd0;
  localparam logic [IDX_W-1:0] IDX_DHI = 2'd1;
  localparam logic [IDX_W-1:0] IDX_CMD = 2'd2;
  localparam logic [IDX_W-1:0] IDX_ICL = 2'd3;

  localparam int RUN_BIT = 31;

  typedef struct packed {
    logic [6:0] code;
    logic [7:0] p2;
    logic [7:0] p1;
  } cmd_fields_t;
endpackage

// File: rtl/mbox_data_regs.sv
module mbox_data_regs
  import mbox_pkg::*;
#(
  parameter bit HAS_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              load_res,
  input  logic [WORD_W-1:0] res_lo,
  input  logic [WORD_W-1:0] res_hi,
  output logic [WORD_W-1:0] data_lo,
  output logic [WORD_W-1:0] data_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n)                data_lo <= '0;
    else if (load_res)         data_lo <= res_lo;
    else if (!busy && wr_lo)   data_lo <= wdata;
  end

  generate
    if (HAS_HIGH) begin : g_hi
      always_ff @(posedge clk) begin
        if (!rst_n)              data_hi <= '0;
        else if (load_res)       data_hi <= res_hi;
        else if (!busy && wr_hi) data_hi <= wdata;
      end
    end else begin : g_no_hi
      logic unused_hi;
      assign unused_hi = wr_hi ^ (^res_hi);
      assign data_hi   = '0;
    end
  endgenerate

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !load_res |=> $stable(data_lo) && $stable(data_hi)) else $error("data changed while busy"); // R5
  AST_HI_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_HIGH |-> data_hi == '0) else $error("high word present"); // R9
endmodule

// File: rtl/mbox_iface_reg.sv
module mbox_iface_reg
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic [WORD_W-1:0] wdata,
  input  logic              done,
  input  logic [7:0]        done_err,
  output logic              run,
  output cmd_fields_t       fields,
  output logic [7:0]        err,
  output logic              cmd_valid
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      run_q  <= 1'b0;
      fields <= '0;
      err    <= '0;
    end else begin
      run_q <= run;
      if (run && done) begin
        run <= 1'b0;
        err <= done_err;
      end else if (!run && wr_cmd) begin
        fields <= wdata[30:8];
        run    <= wdata[RUN_BIT];
        if (wdata[RUN_BIT]) err <= '0;
      end
    end
  end

  assign cmd_valid = run & ~run_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid) else $error("strobe longer than one cycle"); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run && !done |=> run && $stable(fields) && $stable(err)) else $error("busy state disturbed"); // R5
  AST_DONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    run && done |=> !run && err == $past(done_err)) else $error("completion not taken"); // R6
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !run && done && !wr_cmd |=> !run && $stable(err) && $stable(fields)) else $error("idle completion acted"); // R10
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr |=> irq) else $error("interrupt dropped"); // R8
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> irq) else $error("interrupt not raised"); // R6
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter bit HAS_HIGH = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        cmd_valid,
  output logic [6:0]  cmd_code,
  output logic [7:0]  cmd_p1,
  output logic [7:0]  cmd_p2,
  output logic [31:0] cmd_data_lo,
  output logic [31:0] cmd_data_hi,
  input  logic        done,
  input  logic [7:0]  done_err,
  input  logic [31:0] done_data_lo,
  input  logic [31:0] done_data_hi
);
  logic        run;
  cmd_fields_t fields;
  logic [7:0]  err;
  logic        finish;
  logic        irq_clr;

  assign finish  = run & done;
  assign irq_clr = bus_wr && bus_addr == IDX_ICL && bus_wdata[0];

  mbox_iface_reg u_iface (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cmd   (bus_wr && bus_addr == IDX_CMD),
    .wdata    (bus_wdata),
    .done     (done),
    .done_err (done_err),
    .run      (run),
    .fields   (fields),
    .err      (err),
    .cmd_valid(cmd_valid)
  );

  mbox_data_regs #(.HAS_HIGH(HAS_HIGH)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (run),
    .wr_lo    (bus_wr && bus_addr == IDX_DLO),
    .wr_hi    (bus_wr && bus_addr == IDX_DHI),
    .wdata    (bus_wdata),
    .load_res (finish && done_err == 8'd0),
    .res_lo   (done_data_lo),
    .res_hi   (done_data_hi),
    .data_lo  (cmd_data_lo),
    .data_hi  (cmd_data_hi)
  );

  mbox_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (finish),
    .clr   (irq_clr),
    .irq   (irq)
  );

  assign cmd_code = fields.code;
  assign cmd_p1   = fields.p1;
  assign cmd_p2   = fields.p2;

  always_comb begin
    unique case (bus_addr)
      IDX_DLO: bus_rdata = cmd_data_lo;
      IDX_DHI: bus_rdata = cmd_data_hi;
      IDX_CMD: bus_rdata = {run, fields, err};
      default: bus_rdata = {31'd0, irq};
    endcase
  end

  AST_CLEAR_ERR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> err == 8'd0) else $error("stale error at start"); // R3
  AST_STROBE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> run) else $error("strobe without busy"); // R4
endmodule

// File: tb/mbox_doorbell_bench.sv
`timescale 1ns/1ps
module mbox_doorbell_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        done = 1'b0;
  logic [7:0]  done_err = '0;
  logic [31:0] done_data_lo = '0, done_data_hi = '0;

  logic [31:0] rdata_a, rdata_b, dlo_a, dhi_a, dlo_b, dhi_b;
  logic        irq_a, irq_b, cv_a, cv_b;
  logic [6:0]  code_a, code_b;
  logic [7:0]  p1_a, p2_a, p1_b, p2_b;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mbox_doorbell #(.HAS_HIGH(1'b1)) u_mbox_doorbell (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq(irq_a), .cmd_valid(cv_a),
    .cmd_code(code_a), .cmd_p1(p1_a), .cmd_p2(p2_a), .cmd_data_lo(dlo_a),
    .cmd_data_hi(dhi_a), .done(done), .done_err(done_err),
    .done_data_lo(done_data_lo), .done_data_hi(done_data_hi));

  mbox_doorbell #(.HAS_HIGH(1'b0)) u_mbox_doorbell_lo (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq(irq_b), .cmd_valid(cv_b),
    .cmd_code(code_b), .cmd_p1(p1_b), .cmd_p2(p2_b), .cmd_data_lo(dlo_b),
    .cmd_data_hi(dhi_b), .done(done), .done_err(done_err),
    .done_data_lo(done_data_lo), .done_data_hi(done_data_hi));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    bus_addr = a;
    #0.5;
  endtask

  task automatic complete(input logic [7:0] e, input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk);
    done = 1'b1; done_err = e; done_data_lo = lo; done_data_hi = hi;
    @(negedge clk);
    done = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] last_cmd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0]);
      chk("R1 reset read", rdata_a, 32'd0);
    end
    chk("R1 reset irq/strobe", {30'd0, irq_a, cv_a}, 32'd0);

    for (int i = 0; i < 16; i++) begin
      logic [31:0] lo_in, hi_in, res_lo, res_hi, exp_lo, exp_hi, cmdw;
      logic [6:0] code; logic [7:0] p1, p2, e;
      lo_in  = 32'h1000_0000 + i * 32'h0101_0011;
      hi_in  = 32'hA5A5_0000 ^ (i * 32'h0003_0107);
      res_lo = 32'hC000_0000 | (i * 32'h0000_1F1F);
      res_hi = ~res_lo;
      code = 7'((i * 11) & 7'h7F);
      p1   = 8'((i * 13) & 8'hFF);
      p2   = 8'hF0 ^ 8'(i);
      e    = (i % 3 == 0) ? 8'd0 : 8'(i + 1);

      wr(2'd0, lo_in);
      wr(2'd1, hi_in);
      rd(2'd0); chk("R2 low word", rdata_a, lo_in);
      rd(2'd1); chk("R2 high word", rdata_a, hi_in);
      chk("R9 high absent", rdata_b, 32'd0);

      wr(2'd2, {1'b1, code, p2, p1, 8'h5A});
      chk("R4 strobe", {31'd0, cv_a}, 32'd1);
      chk("R4 code/params", {9'd0, code_a, p2_a, p1_a}, {9'd0, code, p2, p1});
      chk("R4 data lo", dlo_a, lo_in);
      chk("R4 data hi", dhi_a, hi_in);
      rd(2'd2); cmdw = {1'b1, code, p2, p1, 8'h00};
      chk("R3 command readback", rdata_a, cmdw);
      @(negedge clk); #0.5;
      chk("R4 strobe gone", {31'd0, cv_a}, 32'd0);

      wr(2'd0, 32'hFFFF_FFFF);
      wr(2'd1, 32'hEEEE_EEEE);
      wr(2'd2, 32'h7F00_00FF);
      rd(2'd0); chk("R5 low frozen", rdata_a, lo_in);
      rd(2'd1); chk("R5 high frozen", rdata_a, hi_in);
      rd(2'd2); chk("R5 command frozen", rdata_a, cmdw);

      complete(e, res_lo, res_hi);
      rd(2'd2); chk("R6 completion word", rdata_a, {1'b0, code, p2, p1, e});
      chk("R6 irq raised", {31'd0, irq_a}, 32'd1);
      exp_lo = (e == 8'd0) ? res_lo : lo_in;
      exp_hi = (e == 8'd0) ? res_hi : hi_in;
      rd(2'd0); chk("R7 result low", rdata_a, exp_lo);
      rd(2'd1); chk("R7 result high", rdata_a, exp_hi);
      chk("R9 result high dropped", rdata_b, 32'd0);

      complete(8'h77, 32'h1234_5678, 32'h9ABC_DEF0);
      rd(2'd2); chk("R10 idle completion word", rdata_a, {1'b0, code, p2, p1, e});
      rd(2'd0); chk("R10 idle completion data", rdata_a, exp_lo);

      wr(2'd3, 32'd0);
      chk("R8 zero write keeps irq", {31'd0, irq_a}, 32'd1);
      wr(2'd3, 32'd1);
      chk("R8 clear", {31'd0, irq_a}, 32'd0);
      complete(8'h00, 32'd0, 32'd0);
      chk("R10 idle completion no irq", {31'd0, irq_a}, 32'd0);
      last_cmd = {1'b0, code, p2, p1, e};
    end

    // R11: store fields without starting
    wr(2'd2, {1'b0, 7'h12, 8'h34, 8'h56, 8'hAA});
    chk("R11 no strobe", {31'd0, cv_a}, 32'd0);
    rd(2'd2); chk("R11 stored fields", rdata_a, {1'b0, 7'h12, 8'h34, 8'h56, last_cmd[7:0]});
    @(negedge clk); #0.5;
    chk("R11 still no strobe", {31'd0, cv_a}, 32'd0);

    // R8: completion and clear in the same cycle, set wins
    wr(2'd2, 32'h8100_0000);
    @(negedge clk);
    done = 1'b1; done_err = 8'h00;
    bus_addr = 2'd3; bus_wdata = 32'd1; bus_wr = 1'b1;
    @(negedge clk);
    done = 1'b0; bus_wr = 1'b0;
    chk("R8 set wins over clear", {31'd0, irq_a}, 32'd1);
    rd(2'd2); chk("R6 busy cleared", {31'd0, rdata_a[31]}, 32'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule